// File: doc/BRIEF.md
# Injected Conversion Sequence Controller

This block runs a short, high-priority group of analog-to-digital conversions. A configuration bank holds the number of conversions (one to four), which external trigger input to watch, the trigger edge mode, and one channel number per slot. A sequence is launched either by a software start pulse or by a qualifying edge on the selected trigger input. The block then walks the slots in order and issues one conversion request per slot to the converter.

The converter interface is a valid/ready style handshake. `conv_req_valid` is raised with the slot's channel on `conv_req_ch`. `conv_done` acts as the ready/acknowledge: a cycle with both high completes that slot. The converter may stall for any number of cycles by holding `conv_done` low. During a stall the request and its channel stay unchanged. A `conv_done` seen while no request is pending has no effect. `conv_req_valid` also serves as the busy flag. While it is high, configuration writes, software starts and trigger edges are dropped and nothing is queued. A one-cycle `seq_done` pulse marks the end of the sequence.

Top module: `inj_seq_ctrl`

## Requirements
- R1: With length field n (0..3) a started sequence issues exactly n+1 requests. `seq_done` follows only the (n+1)-th completed handshake.
- R2: Requests follow slot order 0, 1, 2, 3. Slot k's channel occupies bits [5k+4:5k] of `cfg_ch`.
- R3: Once raised, `conv_req_valid` and `conv_req_ch` stay stable until a cycle with `conv_done` high.
- R4: A one-cycle `sw_start` while idle launches a sequence in every edge mode. The first request is visible in the following cycle.
- R5: Edge mode 0 disables hardware triggering, so trigger edges launch nothing.
- R6: Edge mode 1 starts on a rising edge, mode 2 on a falling edge, and mode 3 on either edge. A non-matching edge launches nothing.
- R7: `cfg_tsel` picks the watched trigger input by index. Edges on the other inputs launch nothing.
- R8: A configuration write (`cfg_we`) takes effect only while no sequence is active. Writes made during a sequence are discarded.
- R9: Software starts and trigger edges that occur while a sequence is active are ignored and not queued.
- R10: `seq_done` lasts exactly one cycle. It occurs in the first cycle in which `conv_req_valid` is low after the final handshake.
- R11: After reset there is no request and no `seq_done`. The configuration is length 1, all channels 0 and hardware triggering off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_len | input | LEN_W | Conversion count minus one |
| cfg_tsel | input | TSEL_W | Index of the watched trigger input |
| cfg_mode | input | 2 | Edge mode: 0 off, 1 rising, 2 falling, 3 both |
| cfg_ch | input | SLOTS*CH_W | Packed slot channels, slot 0 in the low bits |
| sw_start | input | 1 | Software start pulse |
| trig_in | input | NUM_TRIG | Asynchronous external trigger inputs |
| conv_req_valid | output | 1 | Conversion request pending (also the busy flag) |
| conv_req_ch | output | CH_W | Channel of the pending request |
| conv_done | input | 1 | Converter acknowledge that completes the pending request |
| seq_done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The assertions check on every cycle that a pending request never drops or changes channel before its acknowledge, that `seq_done` is a single cycle with the request low, and that the number of handshakes equals the programmed length plus one. They also check that the configuration registers hold still while a request is pending. The bench scenarios cover what depends on the stimulus history: which edge mode or trigger input launches a sequence, the slot order of channels, and the fact that dropped writes and dropped starts leave no trace in later sequences.

// File: rtl/inj_seq_pkg.sv
`timescale 1ns/1ps
package inj_seq_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_mode_e;

  localparam int DEF_SLOTS    = 4;
  localparam int DEF_CH_W     = 5;
  localparam int DEF_NUM_TRIG = 2;
endpackage

// File: rtl/inj_trig_edge.sv
`timescale 1ns/1ps
module inj_trig_edge
  import inj_seq_pkg::*;
#(
  parameter int NUM_TRIG = DEF_NUM_TRIG,
  parameter int TSEL_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic [TSEL_W-1:0]   sel,
  input  edge_mode_e          mode,
  output logic                hit
);
  logic [NUM_TRIG-1:0] rise_v;
  logic [NUM_TRIG-1:0] fall_v;

  // Two synchronizer flops plus one history flop per input
  for (genvar gi = 0; gi < NUM_TRIG; gi++) begin : g_in
    logic [2:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[1:0], trig_in[gi]};
    end
    assign rise_v[gi] =  pipe[1] & ~pipe[2];
    assign fall_v[gi] = ~pipe[1] &  pipe[2];
  end

  logic r_sel, f_sel, sel_ok;
  always_comb begin
    sel_ok = (int'(sel) < NUM_TRIG);
    r_sel  = sel_ok ? rise_v[sel] : 1'b0;
    f_sel  = sel_ok ? fall_v[sel] : 1'b0;
    unique case (mode)
      EDGE_OFF:  hit = 1'b0;
      EDGE_RISE: hit = r_sel;
      EDGE_FALL: hit = f_sel;
      EDGE_ANY:  hit = r_sel | f_sel;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/inj_cfg_bank.sv
`timescale 1ns/1ps
module inj_cfg_bank
  import inj_seq_pkg::*;
#(
  parameter int SLOTS  = DEF_SLOTS,
  parameter int CH_W   = DEF_CH_W,
  parameter int LEN_W  = 2,
  parameter int TSEL_W = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic                  lock,
  input  logic [LEN_W-1:0]      len_in,
  input  logic [TSEL_W-1:0]     tsel_in,
  input  logic [1:0]            mode_in,
  input  logic [SLOTS*CH_W-1:0] ch_in,
  output logic [LEN_W-1:0]      len_q,
  output logic [TSEL_W-1:0]     tsel_q,
  output edge_mode_e            mode_q,
  output logic [SLOTS*CH_W-1:0] ch_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      tsel_q <= '0;
      mode_q <= EDGE_OFF;
      ch_q   <= '0;
    end else if (we && !lock) begin
      len_q  <= len_in;
      tsel_q <= tsel_in;
      mode_q <= edge_mode_e'(mode_in);
      ch_q   <= ch_in;
    end
  end
endmodule

// File: rtl/inj_slot_seq.sv
`timescale 1ns/1ps
module inj_slot_seq #(
  parameter int SLOTS = 4,
  parameter int CH_W  = 5,
  parameter int LEN_W = 2,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [LEN_W-1:0]      len,
  input  logic [SLOTS*CH_W-1:0] ch_flat,
  input  logic                  done,
  output logic                  busy,
  output logic [CH_W-1:0]       req_ch,
  output logic                  eos
);
  logic [IDX_W-1:0] idx;
  logic             last;

  assign last   = (idx == IDX_W'(len));
  assign req_ch = ch_flat[idx*CH_W +: CH_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      eos  <= 1'b0;
    end else begin
      eos <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          idx  <= '0;
        end
      end else if (done) begin
        if (last) begin
          busy <= 1'b0;
          eos  <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/inj_seq_ctrl.sv
`timescale 1ns/1ps
module inj_seq_ctrl
  import inj_seq_pkg::*;
#(
  parameter int SLOTS    = DEF_SLOTS,
  parameter int CH_W     = DEF_CH_W,
  parameter int NUM_TRIG = DEF_NUM_TRIG,
  localparam int LEN_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int TSEL_W  = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [LEN_W-1:0]      cfg_len,
  input  logic [TSEL_W-1:0]     cfg_tsel,
  input  logic [1:0]            cfg_mode,
  input  logic [SLOTS*CH_W-1:0] cfg_ch,
  input  logic                  sw_start,
  input  logic [NUM_TRIG-1:0]   trig_in,
  output logic                  conv_req_valid,
  output logic [CH_W-1:0]       conv_req_ch,
  input  logic                  conv_done,
  output logic                  seq_done
);
  logic [LEN_W-1:0]      len_q;
  logic [TSEL_W-1:0]     tsel_q;
  edge_mode_e            mode_q;
  logic [SLOTS*CH_W-1:0] ch_q;
  logic                  trig_hit;
  logic                  busy;
  logic                  launch;

  inj_cfg_bank #(.SLOTS(SLOTS), .CH_W(CH_W), .LEN_W(LEN_W), .TSEL_W(TSEL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .lock(busy),
    .len_in(cfg_len), .tsel_in(cfg_tsel), .mode_in(cfg_mode), .ch_in(cfg_ch),
    .len_q(len_q), .tsel_q(tsel_q), .mode_q(mode_q), .ch_q(ch_q)
  );

  inj_trig_edge #(.NUM_TRIG(NUM_TRIG), .TSEL_W(TSEL_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
    .sel(tsel_q), .mode(mode_q), .hit(trig_hit)
  );

  // Starts seen while busy are simply dropped
  assign launch = !busy && (sw_start || trig_hit);

  inj_slot_seq #(.SLOTS(SLOTS), .CH_W(CH_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(launch), .len(len_q), .ch_flat(ch_q),
    .done(conv_done), .busy(busy), .req_ch(conv_req_ch), .eos(seq_done)
  );

  assign conv_req_valid = busy;
endmodule

// File: rtl/inj_seq_checker.sv
`timescale 1ns/1ps
module inj_seq_checker #(
  parameter int SLOTS  = 4,
  parameter int CH_W   = 5,
  parameter int LEN_W  = 2,
  parameter int TSEL_W = 1,
  localparam int CNT_W = LEN_W + 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic [CH_W-1:0]       req_ch,
  input logic                  done,
  input logic                  eos,
  input logic [LEN_W-1:0]      len_q,
  input logic [TSEL_W-1:0]     tsel_q,
  input logic [1:0]            mode_q,
  input logic [SLOTS*CH_W-1:0] ch_q
);
  logic [CNT_W-1:0] hs_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hs_cnt <= '0;
    else if (eos)              hs_cnt <= '0;
    else if (req_valid && done) hs_cnt <= hs_cnt + 1'b1;
  end

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !done |=> req_valid);

  assert_ch_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !done |=> $stable(req_ch));

  assert_eos_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eos |=> !eos);

  assert_eos_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eos |-> !req_valid);

  assert_hs_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    eos |-> hs_cnt == CNT_W'({1'b0, len_q}) + CNT_W'(1));

  assert_cfg_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> $stable(len_q) && $stable(tsel_q) && $stable(mode_q) && $stable(ch_q));
endmodule

bind inj_seq_ctrl inj_seq_checker #(
  .SLOTS(SLOTS), .CH_W(CH_W), .LEN_W(LEN_W), .TSEL_W(TSEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(conv_req_valid), .req_ch(conv_req_ch),
  .done(conv_done), .eos(seq_done), .len_q(len_q), .tsel_q(tsel_q),
  .mode_q(mode_q), .ch_q(ch_q)
);

// File: tb/inj_seq_ctrl_tb.sv
`timescale 1ns/1ps
module inj_seq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_len = '0;
  logic [0:0]  cfg_tsel = '0;
  logic [1:0]  cfg_mode = '0;
  logic [19:0] cfg_ch = '0;
  logic        sw_start = 1'b0;
  logic [1:0]  trig_in = '0;
  logic        conv_req_valid;
  logic [4:0]  conv_req_ch;
  logic        conv_done = 1'b0;
  logic        seq_done;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  inj_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len),
    .cfg_tsel(cfg_tsel), .cfg_mode(cfg_mode), .cfg_ch(cfg_ch),
    .sw_start(sw_start), .trig_in(trig_in), .conv_req_valid(conv_req_valid),
    .conv_req_ch(conv_req_ch), .conv_done(conv_done), .seq_done(seq_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [19:0] pk(input int a, input int b, input int c, input int d);
    return {5'(d), 5'(c), 5'(b), 5'(a)};
  endfunction

  task automatic cfg(input int len, input int tsel, input int mode, input logic [19:0] ch);
    @(negedge clk);
    cfg_we = 1'b1; cfg_len = 2'(len); cfg_tsel = 1'(tsel);
    cfg_mode = 2'(mode); cfg_ch = ch;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic sw_pulse();
    @(negedge clk); sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
  endtask

  task automatic idle_check(input int cyc, input string req);
    repeat (cyc) @(negedge clk);
    chk(!conv_req_valid, req, int'(conv_req_valid), 0);
  endtask

  // Converter model: serves n requests, stalling lat cycles on each
  task automatic serve(input int n, input logic [19:0] chs, input int lat, input string req);
    for (int s = 0; s < n; s++) begin
      int k = 0;
      while (!conv_req_valid && k < 20) begin @(negedge clk); k++; end
      chk(conv_req_valid, req, int'(conv_req_valid), 1);
      chk(conv_req_ch == chs[s*5 +: 5], "R2", int'(conv_req_ch), int'(chs[s*5 +: 5]));
      for (int w = 0; w < lat; w++) begin
        @(negedge clk);
        chk(conv_req_valid && conv_req_ch == chs[s*5 +: 5], "R3",
            int'(conv_req_ch), int'(chs[s*5 +: 5]));
      end
      conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
      if (s < n - 1) chk(!seq_done && conv_req_valid, "R1", int'(seq_done), 0);
    end
    chk(seq_done && !conv_req_valid, "R10", int'(seq_done), 1);
    @(negedge clk);
    chk(!seq_done, "R10", int'(seq_done), 0);
  endtask

  task automatic t_reset();
    chk(!conv_req_valid, "R11", int'(conv_req_valid), 0);
    chk(!seq_done, "R11", int'(seq_done), 0);
    trig_in = 2'b01;
    idle_check(5, "R11");
    trig_in = 2'b00;
    idle_check(5, "R11");
    sw_pulse();
    chk(conv_req_valid, "R4", int'(conv_req_valid), 1);
    serve(1, pk(0, 0, 0, 0), 0, "R11");
  endtask

  task automatic t_lengths();
    cfg(3, 0, 0, pk(7, 19, 2, 11));
    sw_pulse();
    serve(4, pk(7, 19, 2, 11), 2, "R1");
    cfg(1, 0, 0, pk(5, 9, 13, 17));
    sw_pulse();
    serve(2, pk(5, 9, 13, 17), 0, "R1");
    idle_check(4, "R1");
    cfg(2, 0, 3, pk(18, 1, 16, 3));
    sw_pulse();
    chk(conv_req_valid, "R4", int'(conv_req_valid), 1);
    serve(3, pk(18, 1, 16, 3), 1, "R2");
  endtask

  task automatic t_mode_off();
    cfg(0, 0, 0, pk(3, 0, 0, 0));
    trig_in[0] = 1'b1;
    idle_check(6, "R5");
    trig_in[0] = 1'b0;
    idle_check(6, "R5");
  endtask

  task automatic t_rise_fall_both();
    cfg(0, 0, 1, pk(4, 0, 0, 0));
    @(negedge clk); trig_in[0] = 1'b1;
    serve(1, pk(4, 0, 0, 0), 0, "R6");
    trig_in[0] = 1'b0;
    idle_check(6, "R6");
    cfg(0, 0, 2, pk(14, 0, 0, 0));
    trig_in[0] = 1'b1;
    idle_check(6, "R6");
    trig_in[0] = 1'b0;
    serve(1, pk(14, 0, 0, 0), 0, "R6");
    cfg(0, 0, 3, pk(10, 0, 0, 0));
    trig_in[0] = 1'b1;
    serve(1, pk(10, 0, 0, 0), 0, "R6");
    trig_in[0] = 1'b0;
    serve(1, pk(10, 0, 0, 0), 0, "R6");
  endtask

  task automatic t_select();
    cfg(0, 1, 1, pk(6, 0, 0, 0));
    trig_in[0] = 1'b1;
    idle_check(6, "R7");
    trig_in[1] = 1'b1;
    serve(1, pk(6, 0, 0, 0), 0, "R7");
    trig_in = 2'b00;
    idle_check(6, "R7");
  endtask

  task automatic t_lock();
    cfg(0, 0, 0, pk(8, 0, 0, 0));
    sw_pulse();
    cfg(3, 0, 1, pk(1, 1, 1, 1));
    serve(1, pk(8, 0, 0, 0), 0, "R8");
    trig_in[0] = 1'b1;
    idle_check(6, "R8");
    trig_in[0] = 1'b0;
    idle_check(6, "R8");
    sw_pulse();
    serve(1, pk(8, 0, 0, 0), 0, "R8");
  endtask

  task automatic t_no_queue();
    cfg(0, 0, 3, pk(12, 0, 0, 0));
    sw_pulse();
    @(negedge clk); sw_start = 1'b1; trig_in[0] = 1'b1;
    @(negedge clk); sw_start = 1'b0;
    repeat (2) @(negedge clk);
    trig_in[0] = 1'b0;
    serve(1, pk(12, 0, 0, 0), 8, "R9");
    idle_check(8, "R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lengths();
    t_mode_off();
    t_rise_fall_both();
    t_select();
    t_lock();
    t_no_queue();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule